// File: doc/BRIEF.md
# Card Reset and Answer Timing Monitor

This block controls the reset line of a smart card during activation and measures when the card starts to answer. Software raises a request bit. The block then counts card clock cycles, which arrive as a one-cycle enable tick. When the count equals a programmed threshold, the block drives card reset high. It then watches the card's data line for the first start bit of the answer. The data line is sampled only after a fixed blanking window.

There are three possible outcomes:
- **Early answer:** the answer arrives before reset has been driven high. The run fails and reset is never driven high.
- **Success:** the answer arrives after reset has been driven high. The run completes.
- **Timeout:** the counter reaches its top value with no answer.

In every case the counter stops at the result. On an answer, the count at that moment is kept in a capture register. Dropping the request bit releases reset and returns the block to idle.

Top module: `reset_answer_timer`

## Requirements
- R1: A run starts on the first clock with `rst_req` high while idle, with the count at 0. During a run the count advances by exactly one for each clock on which `cclk_tick` is high, and it holds on all other clocks.
- R2: `card_rst` goes high one clock after the count equals `threshold` during a run with no answer yet. It stays high until `rst_req` is cleared.
- R3: A falling edge on `card_io` while the count is below 200 is ignored. No flag changes, the capture register is unchanged, and the run continues.
- R4: A start bit seen at a count of 200 or more while `card_rst` is low sets `early_fail`. It loads `capture` with the count, and `card_rst` stays low for the rest of that run.
- R5: A start bit seen while `card_rst` is high sets `answer_ok` and loads `capture` with the count.
- R6: After a start bit or a timeout, the count is frozen. Further ticks neither raise `card_rst` nor cause a timeout, and later edges on `card_io` do not change `capture`.
- R7: If the count reaches 65535 with no start bit, `timed_out` is set. Counting stops and `capture` keeps its previous value.
- R8: At most one of `answer_ok`, `early_fail` and `timed_out` is high at any time. All three clear when a new run starts, and they hold their value otherwise.
- R9: Clearing `rst_req` drives `card_rst` low on the next clock, clears the count and returns the block to idle. `capture` keeps its value.
- R10: `card_io` passes through a two-flop synchronizer. A start bit is a high-to-low transition of the synchronized line, so a line that is already low when a run starts is not an answer until it has risen and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Software request to run the reset sequence (level) |
| cclk_tick | input | 1 | One-clock pulse per card clock cycle |
| card_io | input | 1 | Card data line, asynchronous, idles high |
| threshold | input | 16 | Count at which card reset is driven high |
| card_rst | output | 1 | Reset line to the card |
| capture | output | 16 | Count at the arrival of the answer start bit |
| answer_ok | output | 1 | Answer arrived after reset was driven high |
| early_fail | output | 1 | Answer arrived before reset was driven high |
| timed_out | output | 1 | Counter reached its top value with no answer |

## Verification
The embedded properties are checked on every cycle:
- reset rises only one clock after the count has equaled the threshold;
- reset never appears together with an early failure;
- the result flags are mutually exclusive;
- any captured value lies at or beyond the blanking limit;
- the count is frozen once a result exists;
- dropping the request clears reset and the count on the next clock.

Only the directed scenarios can show the exact captured counts, the blanking of a real glitch, the held-low line that must rise before it can count as an answer, and the 65535-cycle timeout. These depend on specific tick sequences and line waveforms.

// File: rtl/rat_pkg.sv
package rat_pkg;
   typedef enum logic [1:0] {
      RAT_IDLE = 2'd0,
      RAT_RUN  = 2'd1,
      RAT_DONE = 2'd2
   } rat_state_e;

   typedef enum logic [1:0] {
      RES_NONE    = 2'd0,
      RES_OK      = 2'd1,
      RES_EARLY   = 2'd2,
      RES_TIMEOUT = 2'd3
   } rat_result_e;
endpackage

// File: rtl/rat_io_sync.sv
module rat_io_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_sync,
   output logic fall_seen
);
   logic [STAGES-1:0] chain;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rat_io_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain[STAGES-1];
   end

   assign line_sync = chain[STAGES-1];
   assign fall_seen = prev_q & ~chain[STAGES-1];

   a_r10_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      fall_seen |-> $past(line_sync));
endmodule

// File: rtl/rat_counter.sv
module rat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] count,
   output logic             at_top
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   if (CNT_W < 8) begin : g_bad_width
      $error("rat_counter: CNT_W must be at least 8");
   end

   assign at_top = (count == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clr)            count <= '0;
      else if (adv && !at_top) count <= count + 1'b1;
   end

   a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && adv && !at_top) |=> (count == $past(count) + 1'b1));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(count));
endmodule

// File: rtl/reset_answer_timer.sv
module reset_answer_timer
   import rat_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int BLANK_CYCLES = 200,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_req,
   input  logic             cclk_tick,
   input  logic             card_io,
   input  logic [CNT_W-1:0] threshold,
   output logic             card_rst,
   output logic [CNT_W-1:0] capture,
   output logic             answer_ok,
   output logic             early_fail,
   output logic             timed_out
);
   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYCLES);

   if (BLANK_CYCLES < 0 || BLANK_CYCLES >= (2 ** CNT_W) - 1) begin : g_bad_blank
      $error("reset_answer_timer: BLANK_CYCLES out of counter range");
   end

   rat_state_e       st_q;
   rat_result_e      res_q;
   logic [CNT_W-1:0] cnt;
   logic             cnt_top;
   logic             io_sync;
   logic             io_fall;
   logic             start_bit;
   logic             cnt_adv;
   logic             cnt_clr;

   rat_io_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (card_io),
      .line_sync (io_sync),
      .fall_seen (io_fall)
   );

   // answer edge counts only in a run and past the blanking window
   assign start_bit = (st_q == RAT_RUN) && io_fall && (cnt >= BLANK_V);
   assign cnt_clr   = (st_q == RAT_IDLE) || !rst_req;
   assign cnt_adv   = (st_q == RAT_RUN) && cclk_tick && !start_bit;

   rat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .adv    (cnt_adv),
      .count  (cnt),
      .at_top (cnt_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RAT_IDLE;
         res_q    <= RES_NONE;
         card_rst <= 1'b0;
         capture  <= '0;
      end else if (!rst_req) begin
         st_q     <= RAT_IDLE;
         card_rst <= 1'b0;
      end else begin
         unique case (st_q)
            RAT_IDLE: begin
               st_q  <= RAT_RUN;
               res_q <= RES_NONE;
            end
            RAT_RUN: begin
               if (start_bit) begin
                  capture <= cnt;
                  res_q   <= card_rst ? RES_OK : RES_EARLY;
                  st_q    <= RAT_DONE;
               end else if (cnt_top) begin
                  res_q <= RES_TIMEOUT;
                  st_q  <= RAT_DONE;
               end else if (cnt == threshold) begin
                  card_rst <= 1'b1;
               end
            end
            default: st_q <= RAT_DONE;
         endcase
      end
   end

   assign answer_ok  = (res_q == RES_OK);
   assign early_fail = (res_q == RES_EARLY);
   assign timed_out  = (res_q == RES_TIMEOUT);

   a_r2_rst_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_rst) |-> ($past(cnt) == $past(threshold)));
   a_r4_no_rst_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      early_fail |-> !card_rst);
   a_r8_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({answer_ok, early_fail, timed_out}));
   a_r3_capture_past_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (answer_ok || early_fail) |-> (capture >= BLANK_V));
   a_r6_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RAT_DONE && rst_req) |=> $stable(cnt));
   a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req |=> (!card_rst && cnt == '0 && $stable(capture)));
endmodule

// File: tb/reset_answer_timer_bench.sv
module reset_answer_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic        cclk_tick = 1'b0;
   logic        card_io = 1'b1;
   logic [15:0] threshold = 16'd0;
   logic        card_rst;
   logic [15:0] capture;
   logic        answer_ok, early_fail, timed_out;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   reset_answer_timer u_reset_answer_timer (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .cclk_tick(cclk_tick),
      .card_io(card_io), .threshold(threshold), .card_rst(card_rst),
      .capture(capture), .answer_ok(answer_ok), .early_fail(early_fail),
      .timed_out(timed_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cclk_tick = 1'b1;
         @(posedge clk);
         #1;
      end
      cclk_tick = 1'b0;
   endtask

   task automatic io_fall();
      card_io = 1'b0;
      wait_clk(4);
   endtask

   task automatic io_rise();
      card_io = 1'b1;
      wait_clk(4);
   endtask

   task automatic new_run(input logic [15:0] thr, input logic io_level);
      rst_req = 1'b0;
      card_io = io_level;
      wait_clk(4);
      threshold = thr;
      rst_req = 1'b1;
      wait_clk(2);
   endtask

   task automatic t_reset_state();
      chk("R9 reset card_rst", card_rst, 0);
      chk("R9 reset capture", capture, 0);
      chk("R8 reset flags", {answer_ok, early_fail, timed_out}, 0);
   endtask

   task automatic t_success();
      new_run(16'd300, 1'b1);
      ticks(299);
      wait_clk(2);
      chk("R2 no rst before threshold", card_rst, 0);
      ticks(1);
      wait_clk(2);
      chk("R2 rst at threshold", card_rst, 1);
      ticks(50);
      io_fall();
      chk("R5 ok flag", answer_ok, 1);
      chk("R5 capture", capture, 350);
      ticks(20);
      io_rise();
      io_fall();
      chk("R6 capture frozen", capture, 350);
      chk("R6 no timeout", timed_out, 0);
      chk("R2 rst held", card_rst, 1);
      rst_req = 1'b0;
      wait_clk(1);
      chk("R9 rst released", card_rst, 0);
      chk("R9 capture kept", capture, 350);
      chk("R8 flag held in idle", answer_ok, 1);
   endtask

   task automatic t_blank_and_early();
      new_run(16'd500, 1'b1);
      chk("R8 flags cleared on new run", {answer_ok, early_fail, timed_out}, 0);
      ticks(100);
      io_fall();
      io_rise();
      chk("R3 blanked edge ignored", {answer_ok, early_fail, timed_out}, 0);
      chk("R3 capture unchanged", capture, 350);
      ticks(150);
      io_fall();
      chk("R4 early flag", early_fail, 1);
      chk("R4 capture", capture, 250);
      chk("R4 no rst", card_rst, 0);
      io_rise();
      ticks(400);
      wait_clk(2);
      chk("R6 no rst after fail", card_rst, 0);
      chk("R6 still early", {answer_ok, early_fail, timed_out}, 3'b010);
   endtask

   task automatic t_held_low();
      new_run(16'd250, 1'b0);
      ticks(260);
      wait_clk(4);
      chk("R10 held low not an answer", {answer_ok, early_fail, timed_out}, 0);
      chk("R2 rst during held low", card_rst, 1);
      io_rise();
      io_fall();
      chk("R10 answer after rise", answer_ok, 1);
      chk("R10 capture", capture, 260);
   endtask

   task automatic t_tick_gating();
      new_run(16'd210, 1'b1);
      ticks(209);
      wait_clk(20);
      chk("R1 idle clocks hold count", card_rst, 0);
      ticks(1);
      wait_clk(2);
      chk("R1 one tick per step", card_rst, 1);
   endtask

   task automatic t_timeout();
      new_run(16'd1000, 1'b1);
      ticks(65534);
      wait_clk(2);
      chk("R7 no timeout below top", timed_out, 0);
      ticks(1);
      wait_clk(2);
      chk("R7 timeout flag", timed_out, 1);
      chk("R7 capture kept", capture, 260);
      io_fall();
      chk("R6 no answer after timeout", answer_ok, 0);
      chk("R6 capture after timeout", capture, 260);
      io_rise();
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset_state();
      t_success();
      t_blank_and_early();
      t_held_low();
      t_tick_gating();
      t_timeout();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule